// File: doc/BRIEF.md
# SPI Master Controller with Word FIFOs

This block is an SPI master that software drives through a small register bus. The bus has an address, write and read strobes, and write and read data. Software picks a word length from 1 to 32 bits, a clock divider, the clock polarity and phase, and the level of up to four chip-select lines. It then pushes words into a transmit FIFO. The shift engine starts on its own as soon as transmission is enabled and a word is waiting. It sends each word most significant bit first on `mosi`.

When receiving is enabled along with transmitting, each word sampled from `miso` is stored in a receive FIFO. Software pops it from the same address it pushes to. A status register shows when all transmit work is finished, meaning the FIFO is drained and the last bit has left the shifter. It also shows when a word is currently shifting, both FIFO fill states, and two sticky error bits for misuse of the data address.

Top module: `spim_ctrl`

Register map (3-bit address):

- 0, configuration:
  - [4:0] word length (0 = 32 bits)
  - [5] polarity
  - [6] phase
  - [11:8] chip selects (active low)
- 1, direction: [0] transmit enable, [1] receive enable
- 2, divider
- 3, FIFO hold: [0]
- 4, data
- 5, status:
  - [0] transmit finished
  - [1] shifting
  - [2] transmit FIFO full
  - [3] receive FIFO empty
  - [4] push-overflow sticky
  - [5] pop-underflow sticky

Any write to the status register clears both sticky bits.

## Requirements
- R1: After reset, every chip select is high, `sclk` and `mosi` are 0, and status reads with bit 0 (transmit finished) and bit 3 (receive FIFO empty) set and every other bit clear.
- R2: Word-length field values 1 to 31 shift exactly that many bits per word, and the value 0 shifts 32 bits. Bits leave most significant bit first.
- R3: Bits [11:8] of the configuration register appear unchanged on `cs_n[3:0]`.
- R4: With only transmit enabled (direction = 1), shifted words are sent but nothing enters the receive FIFO.
- R5: With direction = 3, every word sampled from `miso` is placed in the receive FIFO and returned, right-aligned and zero-extended, by a read of address 4.
- R6: The `sclk` period is 2 × (divider + 1) clock cycles.
- R7: While FIFO hold bit 0 is 1, both FIFOs are empty and writes to address 4 are dropped. Clearing the bit lets pushes resume.
- R8: Status bit 1 is set while a word is shifting. Status bit 0 is set only when the transmit FIFO is empty and the shifter is idle.
- R9: A word waiting in the transmit FIFO starts shifting without further action once transmit is enabled. It stays queued while transmit is disabled.
- R10: A push to a full transmit FIFO and a pop from an empty receive FIFO are ignored. The pop reads 0. They set status bit 4 and bit 5 respectively, and both bits stay set until the status register is written.
- R11: In all four polarity/phase combinations, `mosi` changes on one `sclk` edge and `miso` is sampled on the other. The leading edge samples when phase is 0, and the trailing edge samples when phase is 1. When idle, `sclk` rests at the polarity level and `mosi` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops the receive FIFO at address 4) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the same cycle as `rd_en` |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Chip selects, active low |

## Verification
The bench loops `mosi` back to `miso`, sometimes inverted, and watches the serial bus from the slave side. This exposes these faults:

- A shifter that sends least significant bit first, or miscounts the word length (especially the 0-means-32 encoding), shows wrong monitored bits.
- Sampling and launching on the same edge corrupts the inverted echo.
- A captured word that is not right-aligned corrupts it as well.

The edge cases tested are these:

- A word pushed while transmit is disabled must wait.
- A transmit-only transfer must leave the receive FIFO empty.
- A push while the FIFO hold is set must vanish rather than appear after release.
- An over-full push must set a sticky bit that survives until cleared, and so must a pop from an empty receive FIFO.

A design whose finished flag ignores the shifter would report completion while the last word is still on the wire.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CFG   = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIR   = 3'd1;
  localparam logic [ADDR_W-1:0] A_DIV   = 3'd2;
  localparam logic [ADDR_W-1:0] A_HOLD  = 3'd3;
  localparam logic [ADDR_W-1:0] A_DATA  = 3'd4;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd5;

  // Decoded word length: field 0 stands for a full 32-bit word.
  function automatic logic [5:0] len_bits(input logic [4:0] field);
    return (field == 5'd0) ? 6'd32 : {1'b0, field};
  endfunction

  // Move an n-bit right-aligned word to the top of the shift register.
  function automatic logic [WORD_W-1:0] msb_align(input logic [WORD_W-1:0] w,
                                                  input logic [5:0] n);
    return w << (6'd32 - n);
  endfunction

  // Number of half periods in one word.
  function automatic logic [6:0] half_count(input logic [5:0] n);
    return {n, 1'b0};
  endfunction
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          full,
  output logic          empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = PW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  wire do_push = push && !full;
  wire do_pop  = pop && !empty;

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign dout  = mem[rp];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
    end
  end

  // R10
  full_push_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> (full && $stable(wp)));
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [31:0]      word,
  input  logic [5:0]       nbits,
  input  logic             cpol,
  input  logic             cpha,
  input  logic [DIV_W-1:0] div,
  input  logic             miso,
  output logic             busy,
  output logic             done,
  output logic             sclk,
  output logic             mosi,
  output logic [31:0]      rx_word
);
  import spim_pkg::*;

  logic [DIV_W-1:0] half_cnt;
  logic [6:0]       edges;
  logic [5:0]       n_q;
  logic             cpha_q, lvl, mosi_q;
  logic [31:0]      sr, rxs;

  wire        tick     = busy && (half_cnt == div);
  wire        leading  = !lvl;
  wire        launch   = (leading == cpha_q);
  wire        last_one = (edges == half_count(n_q) - 7'd1);
  wire [31:0] aligned  = msb_align(word, nbits);

  assign sclk    = cpol ^ lvl;
  assign mosi    = mosi_q;
  assign rx_word = rxs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; half_cnt <= '0; edges <= '0;
      n_q <= 6'd32; cpha_q <= 1'b0; lvl <= 1'b0; mosi_q <= 1'b0;
      sr <= '0; rxs <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1; half_cnt <= '0; edges <= '0; lvl <= 1'b0;
          n_q <= nbits; cpha_q <= cpha; rxs <= '0;
          if (!cpha) begin
            mosi_q <= aligned[31];
            sr     <= aligned << 1;
          end else begin
            mosi_q <= 1'b0;
            sr     <= aligned;
          end
        end
      end else if (tick) begin
        half_cnt <= '0;
        edges    <= edges + 1'b1;
        lvl      <= ~lvl;
        if (launch) begin
          mosi_q <= sr[31];
          sr     <= sr << 1;
        end else begin
          rxs <= {rxs[30:0], miso};
        end
        if (last_one) begin
          busy <= 1'b0; done <= 1'b1; mosi_q <= 1'b0; lvl <= 1'b0;
        end
      end else begin
        half_cnt <= half_cnt + 1'b1;
      end
    end
  end

  // R11
  idle_mosi_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mosi);
  // R11
  idle_sclk_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == cpol));
  // R6
  no_early_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(lvl));
  // R8
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl #(
  parameter int DEPTH = 16,
  parameter int DIV_W = 8,
  parameter int CS_N  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      addr,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  output logic            sclk,
  output logic            mosi,
  input  logic            miso,
  output logic [CS_N-1:0] cs_n
);
  import spim_pkg::*;

  localparam int CS_LSB = 8;

  logic [4:0]       len_q;
  logic             cpol_q, cpha_q, tx_en_q, rx_en_q, hold_q, ovf_q, unf_q;
  logic [CS_N-1:0]  cs_q;
  logic [DIV_W-1:0] div_q;

  logic        tx_empty, tx_full, rx_empty, rx_full;
  logic [31:0] tx_dout, rx_dout, sh_rx;
  logic        sh_busy, sh_done;

  wire wr_cfg  = wr_en && (addr == A_CFG);
  wire wr_dir  = wr_en && (addr == A_DIR);
  wire wr_div  = wr_en && (addr == A_DIV);
  wire wr_hold = wr_en && (addr == A_HOLD);
  wire wr_data = wr_en && (addr == A_DATA);
  wire wr_stat = wr_en && (addr == A_STAT);
  wire rd_data = rd_en && (addr == A_DATA);

  wire start   = tx_en_q && !tx_empty && !sh_busy;
  wire rx_push = sh_done && tx_en_q && rx_en_q;
  wire push_ok = wr_data && !hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0; cpol_q <= 1'b0; cpha_q <= 1'b0; cs_q <= '1;
      tx_en_q <= 1'b0; rx_en_q <= 1'b0; div_q <= '0; hold_q <= 1'b0;
      ovf_q <= 1'b0; unf_q <= 1'b0;
    end else begin
      if (wr_cfg) begin
        len_q  <= wdata[4:0];
        cpol_q <= wdata[5];
        cpha_q <= wdata[6];
        cs_q   <= wdata[CS_LSB +: CS_N];
      end
      if (wr_dir) begin
        tx_en_q <= wdata[0];
        rx_en_q <= wdata[1];
      end
      if (wr_div)  div_q  <= wdata[DIV_W-1:0];
      if (wr_hold) hold_q <= wdata[0];
      if (wr_stat) begin
        ovf_q <= 1'b0;
        unf_q <= 1'b0;
      end else begin
        if (push_ok && tx_full) ovf_q <= 1'b1;
        if (rd_data && rx_empty) unf_q <= 1'b1;
      end
    end
  end

  spim_fifo #(.DW(WORD_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(hold_q), .push(push_ok), .pop(start),
    .din(wdata), .dout(tx_dout), .full(tx_full), .empty(tx_empty));

  spim_fifo #(.DW(WORD_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(hold_q), .push(rx_push), .pop(rd_data),
    .din(sh_rx), .dout(rx_dout), .full(rx_full), .empty(rx_empty));

  spim_shifter #(.DIV_W(DIV_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .word(tx_dout),
    .nbits(len_bits(len_q)), .cpol(cpol_q), .cpha(cpha_q), .div(div_q),
    .miso(miso), .busy(sh_busy), .done(sh_done), .sclk(sclk), .mosi(mosi),
    .rx_word(sh_rx));

  assign cs_n = cs_q;

  always_comb begin
    rdata = '0;
    case (addr)
      A_CFG: begin
        rdata[4:0] = len_q;
        rdata[5]   = cpol_q;
        rdata[6]   = cpha_q;
        rdata[CS_LSB +: CS_N] = cs_q;
      end
      A_DIR:  rdata[1:0] = {rx_en_q, tx_en_q};
      A_DIV:  rdata[DIV_W-1:0] = div_q;
      A_HOLD: rdata[0] = hold_q;
      A_DATA: rdata = rx_empty ? '0 : rx_dout;
      A_STAT: rdata[5:0] = {unf_q, ovf_q, rx_empty, tx_full, sh_busy,
                            tx_empty && !sh_busy};
      default: rdata = '0;
    endcase
  end

  // R9
  auto_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en_q && !tx_empty && !sh_busy) |=> sh_busy);
  // R10
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && tx_full && !wr_stat) |=> ovf_q);
  // R7
  hold_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |=> (tx_empty && rx_empty));
  // R4
  tx_only_no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_done && !rx_en_q && rx_empty && !hold_q) |=> rx_empty);
endmodule

// File: tb/tb_spim_ctrl.sv
module tb_spim_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sclk, mosi, miso;
  logic [3:0]  cs_n;
  logic        echo_inv = 1'b0;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  assign miso = mosi ^ echo_inv;

  spim_ctrl dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n));

  // Slave-side monitor: samples mosi on the edge a slave would use.
  logic        m_cpol = 1'b0, m_cpha = 1'b0;
  logic [31:0] mon_word = '0;
  int          mon_bits = 0;
  always @(sclk) begin
    if (sclk != (m_cpol ^ m_cpha)) begin
      mon_word = {mon_word[30:0], mosi};
      mon_bits = mon_bits + 1;
    end
  end

  int cyc = 0, last_rise = 0, prev_rise = 0;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge sclk) begin
    prev_rise = last_rise;
    last_rise = cyc;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic set_cfg(input logic [4:0] len, input logic pol, input logic pha,
                         input logic [3:0] cs);
    bus_wr(3'd0, {20'd0, cs, 1'b0, pha, pol, len});
    m_cpol = pol; m_cpha = pha;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      bus_rd(3'd5, s);
      if (s[0]) break;
    end
  endtask

  // R1
  task automatic t_reset();
    logic [31:0] s;
    chk("R1 cs_n", {28'd0, cs_n}, 32'hF);
    chk("R1 sclk", {31'd0, sclk}, 32'd0);
    chk("R1 mosi", {31'd0, mosi}, 32'd0);
    bus_rd(3'd5, s);
    chk("R1 status", s, 32'h9);
  endtask

  // R3
  task automatic t_cs();
    set_cfg(5'd8, 1'b0, 1'b0, 4'b1010);
    chk("R3 cs pattern", {28'd0, cs_n}, 32'hA);
    set_cfg(5'd8, 1'b0, 1'b0, 4'b1110);
    chk("R3 cs0 low", {28'd0, cs_n}, 32'hE);
  endtask

  // R2, R5, R11: one word in a given mode and length, echoed back.
  task automatic t_word(input string req, input logic [4:0] len, input logic pol,
                        input logic pha, input logic inv, input logic [31:0] w);
    int b0, n;
    logic [31:0] mask, d;
    n = (len == 0) ? 32 : int'(len);
    mask = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1);
    set_cfg(len, pol, pha, 4'b1110);
    echo_inv = inv;
    bus_wr(3'd2, 32'd1);
    bus_wr(3'd1, 32'd3);
    b0 = mon_bits;
    bus_wr(3'd4, w);
    wait_done();
    chk({req, " bit count"}, mon_bits - b0, n);
    chk({req, " msb-first word"}, mon_word & mask, w & mask);
    chk({req, " idle sclk"}, {31'd0, sclk}, {31'd0, pol});
    bus_rd(3'd4, d);
    chk({req, " R5 captured"}, d, (inv ? ~w : w) & mask);
    bus_wr(3'd1, 32'd0);
    echo_inv = 1'b0;
  endtask

  // R4, R10 underflow
  task automatic t_tx_only();
    logic [31:0] s, d;
    set_cfg(5'd8, 1'b0, 1'b0, 4'b1110);
    bus_wr(3'd1, 32'd1);
    bus_wr(3'd4, 32'h5A);
    wait_done();
    bus_rd(3'd5, s);
    chk("R4 rx fifo empty", {31'd0, s[3]}, 32'd1);
    bus_rd(3'd4, d);
    chk("R10 empty pop reads 0", d, 32'd0);
    bus_rd(3'd5, s);
    chk("R10 underflow sticky", {31'd0, s[5]}, 32'd1);
    bus_rd(3'd5, s);
    chk("R10 underflow stays", {31'd0, s[5]}, 32'd1);
    bus_wr(3'd5, 32'd0);
    bus_rd(3'd5, s);
    chk("R10 underflow cleared", {31'd0, s[5]}, 32'd0);
    bus_wr(3'd1, 32'd0);
  endtask

  // R9, R8, R6
  task automatic t_auto_start();
    logic [31:0] s;
    int b0;
    set_cfg(5'd8, 1'b0, 1'b0, 4'b1110);
    bus_wr(3'd2, 32'd2);
    b0 = mon_bits;
    bus_wr(3'd4, 32'hC3);
    repeat (40) @(negedge clk);
    chk("R9 no shift while disabled", mon_bits - b0, 0);
    bus_rd(3'd5, s);
    chk("R8 not finished with queued word", {31'd0, s[0]}, 32'd0);
    bus_wr(3'd1, 32'd1);
    repeat (3) @(negedge clk);
    bus_rd(3'd5, s);
    chk("R8 busy while shifting", s[1:0], 32'd2);
    wait_done();
    chk("R9 word sent after enable", mon_bits - b0, 8);
    chk("R9 value", mon_word & 32'hFF, 32'hC3);
    chk("R6 sclk period", last_rise - prev_rise, 6);
    bus_rd(3'd5, s);
    chk("R8 idle after word", s[1:0], 32'd1);
    bus_wr(3'd1, 32'd0);
    bus_wr(3'd2, 32'd1);
  endtask

  // R10 overflow, R7 hold
  task automatic t_fill_and_hold();
    logic [31:0] s;
    int b0;
    for (int i = 0; i < 17; i++) bus_wr(3'd4, i);
    bus_rd(3'd5, s);
    chk("R10 tx full", {31'd0, s[2]}, 32'd1);
    chk("R10 overflow sticky", {31'd0, s[4]}, 32'd1);
    bus_wr(3'd5, 32'd0);
    bus_rd(3'd5, s);
    chk("R10 overflow cleared", {31'd0, s[4]}, 32'd0);
    bus_wr(3'd3, 32'd1);
    bus_wr(3'd4, 32'hFF);
    bus_rd(3'd5, s);
    chk("R7 tx emptied under hold", s[2:0], 32'd1);
    bus_wr(3'd3, 32'd0);
    b0 = mon_bits;
    bus_wr(3'd1, 32'd1);
    repeat (60) @(negedge clk);
    chk("R7 held write dropped", mon_bits - b0, 0);
    bus_wr(3'd1, 32'd3);
    bus_wr(3'd4, 32'h81);
    wait_done();
    bus_rd(3'd5, s);
    chk("R7 rx holds word", {31'd0, s[3]}, 32'd0);
    bus_wr(3'd3, 32'd1);
    bus_wr(3'd3, 32'd0);
    bus_rd(3'd5, s);
    chk("R7 rx emptied by hold", {31'd0, s[3]}, 32'd1);
    bus_wr(3'd1, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cs();
    t_word("R2 len32 mode0", 5'd0, 1'b0, 1'b0, 1'b0, 32'hA5C3_1E7F);
    t_word("R2 len12 mode3", 5'd12, 1'b1, 1'b1, 1'b1, 32'h0000_0ABC);
    t_word("R11 mode1", 5'd8, 1'b0, 1'b1, 1'b1, 32'h0000_0096);
    t_word("R11 mode2", 5'd8, 1'b1, 1'b0, 1'b1, 32'h0000_0035);
    t_word("R2 len1", 5'd1, 1'b0, 1'b0, 1'b0, 32'h0000_0001);
    t_tx_only();
    t_auto_start();
    t_fill_and_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule